// File: doc/BRIEF.md
# Coincidence Histogram Counter Array

This block builds a histogram of coincidence words. Each event carries a word up to 11 bits wide. The bit pattern shows which detector channels fired together. The block keeps one saturating counter per word value in on-chip RAM and adds one to the addressed counter for each accepted event. Word value 0 cannot occur as a coincidence, so its slot is used for a grand total of all accepted events. That total supports rate calculations on the host side.

A host-side port controls the array. Raising `pauseReq` freezes counting. While the array is frozen, the host can read any slot by address, or start a sweep that zeroes every slot. Lowering `pauseReq` resumes counting. Increments use a two-stage read-modify-write with a one-entry bypass, so events arriving on consecutive cycles at the same word are all counted.

Top module: `coinc_hist_top`

## Requirements
- R1: After reset, `busy` is low and a host read of address 0 returns 0; the other slots hold no defined value until a clear has run.
- R2: While counting (`pauseReq` low, `busy` low), an event with `evtValid` high and a nonzero `evtWord` adds one to the counter addressed by `evtWord`.
- R3: Every accepted event also adds one to the grand total, which a host read of address 0 returns.
- R4: An event whose word is 0 is ignored: no counter and not the total changes.
- R5: Events on consecutive cycles to the same word, or to alternating words, are all counted.
- R6: Counters and the total saturate at all ones and never wrap to 0.
- R7: Events presented while `pauseReq` is high are not counted.
- R8: When `pauseReq` is high and `busy` is low, `rdEn` with `rdAddr` presents that slot's value on `rdData` in the next cycle. The value includes every event accepted before the pause, including one accepted in the last counting cycle.
- R9: `clearReq` while `pauseReq` is high and `busy` is low zeroes the total. From the next cycle, `busy` stays high for exactly 2^WORD_W cycles while every slot is zeroed, one per clock.
- R10: While `busy` is high, events, host reads and further `clearReq` pulses are ignored.
- R11: After `pauseReq` falls, counting resumes from the held values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtValid | input | 1 | Event strobe |
| evtWord | input | WORD_W | Coincidence word of the event |
| pauseReq | input | 1 | High: counting frozen, host access allowed |
| clearReq | input | 1 | Start the zeroing sweep (honoured while paused and idle) |
| rdEn | input | 1 | Host read strobe |
| rdAddr | input | WORD_W | Host read address; 0 selects the grand total |
| rdData | output | CNT_W | Read result, valid the cycle after the read |
| busy | output | 1 | High while the zeroing sweep runs |

## Verification
The bench drives distinct words, the same word on consecutive cycles, and alternating pairs of words. It also issues a read in the first paused cycle after a burst. Together these separate a correct bypass from a lost or doubled count. Word-0 events and events sent while paused or clearing test that only accepted events touch the counters and the total. A long burst to one word, run with a narrow counter width, shows saturation versus wrap-around. A clear issued over a dirty array, with events and reads injected mid-sweep, shows that every slot is zeroed and that the sweep takes exactly its stated length.

// File: rtl/coinc_hist_pkg.sv
package coinc_hist_pkg;
  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic countEn;   // events may be accepted this cycle
    logic hostRd;    // host read accepted this cycle
    logic clrWr;     // sweep writes zero at clrAddr this cycle
    logic clrTotal;  // sweep starts: zero the grand total
  } dpStrobes_t;
endpackage

// File: rtl/coinc_hist_ctrl.sv
module coinc_hist_ctrl
  import coinc_hist_pkg::*;
#(
  parameter int WORD_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pauseReq,
  input  logic              clearReq,
  input  logic              rdEn,
  output dpStrobes_t        strb,
  output logic [WORD_W-1:0] clrAddr,
  output logic              busy
);
  localparam logic [WORD_W-1:0] LAST_ADDR = {WORD_W{1'b1}};

  logic clearing;
  logic clrStart;

  assign clrStart = pauseReq && clearReq && !clearing;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clearing <= 1'b0;
      clrAddr  <= '0;
    end else if (clrStart) begin
      clearing <= 1'b1;
      clrAddr  <= '0;
    end else if (clearing) begin
      if (clrAddr == LAST_ADDR) clearing <= 1'b0;
      clrAddr <= clrAddr + 1'b1;
    end
  end

  always_comb begin
    strb.countEn  = !pauseReq && !clearing;
    strb.hostRd   = pauseReq && !clearing && rdEn;
    strb.clrWr    = clearing;
    strb.clrTotal = clrStart;
  end

  assign busy = clearing;

  // R9: the sweep ends right after the last address is written
  p_sweep_end_r9: assert property (@(posedge clk) disable iff (!rstN)
    (clearing && clrAddr == LAST_ADDR) |=> !clearing);

  // R9: every sweep begins at address 0
  p_sweep_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clearing) |-> (clrAddr == '0));

  // R10: a clear request during a sweep does not restart it
  p_no_restart_r10: assert property (@(posedge clk) disable iff (!rstN)
    (clearing && clrAddr != LAST_ADDR) |=> (clrAddr == $past(clrAddr) + 1'b1));
endmodule

// File: rtl/coinc_hist_dp.sv
module coinc_hist_dp
  import coinc_hist_pkg::*;
#(
  parameter int WORD_W = 11,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strb,
  input  logic [WORD_W-1:0] clrAddr,
  input  logic              evtValid,
  input  logic [WORD_W-1:0] evtWord,
  input  logic [WORD_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  rdData
);
  localparam int DEPTH = 1 << WORD_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] mem [DEPTH];

  // read port
  logic              accept;
  logic              rdPortEn;
  logic [WORD_W-1:0] rdPortAddr;
  logic [CNT_W-1:0]  memQ;
  logic [WORD_W-1:0] tagAddr;
  logic              fwdHit;
  logic [CNT_W-1:0]  fwdData;
  logic              rdZeroQ;

  // update stage and write port
  logic              s1Valid;
  logic [CNT_W-1:0]  curVal;
  logic [CNT_W-1:0]  incVal;
  logic              wrEn;
  logic [WORD_W-1:0] wrAddr;
  logic [CNT_W-1:0]  wrData;
  logic [CNT_W-1:0]  totalQ;

  assign accept     = strb.countEn && evtValid && (evtWord != '0);
  assign rdPortEn   = accept || strb.hostRd;
  assign rdPortAddr = strb.countEn ? evtWord : rdAddr;

  // RAM: read-before-write on a shared edge
  always_ff @(posedge clk) begin
    if (rdPortEn) memQ <= mem[rdPortAddr];
    if (wrEn)     mem[wrAddr] <= wrData;
  end

  // bypass: a write on the read edge replaces the stale RAM word
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tagAddr <= '0;
      fwdHit  <= 1'b0;
      fwdData <= '0;
      rdZeroQ <= 1'b0;
    end else if (rdPortEn) begin
      tagAddr <= rdPortAddr;
      fwdHit  <= wrEn && (wrAddr == rdPortAddr);
      fwdData <= wrData;
      rdZeroQ <= strb.hostRd && (rdAddr == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) s1Valid <= 1'b0;
    else       s1Valid <= accept;
  end

  assign curVal = fwdHit ? fwdData : memQ;
  assign incVal = (curVal == CNT_MAX) ? curVal : curVal + 1'b1;

  always_comb begin
    wrEn   = strb.clrWr || s1Valid;
    wrAddr = strb.clrWr ? clrAddr : tagAddr;
    wrData = strb.clrWr ? '0 : incVal;
  end

  // grand total lives in a register next to the RAM
  always_ff @(posedge clk) begin
    if (!rstN)                             totalQ <= '0;
    else if (strb.clrTotal)                totalQ <= '0;
    else if (accept && totalQ != CNT_MAX)  totalQ <= totalQ + 1'b1;
  end

  assign rdData = rdZeroQ ? totalQ : curVal;

  // R3: each accepted event adds exactly one to an unsaturated total
  p_total_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (accept && totalQ != CNT_MAX && !strb.clrTotal) |=> (totalQ == $past(totalQ) + 1'b1));

  // R7: without an accepted event or a clear start, the total holds
  p_total_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!accept && !strb.clrTotal) |=> $stable(totalQ));

  // R6: a saturated total stays saturated until cleared
  p_total_sat_r6: assert property (@(posedge clk) disable iff (!rstN)
    (totalQ == CNT_MAX && !strb.clrTotal) |=> (totalQ == CNT_MAX));

  // R6: an increment write never wraps to zero
  p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (s1Valid && !strb.clrWr) |-> (wrData != '0));

  // R10: sweep writes never collide with an in-flight increment
  p_clr_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrWr |-> !s1Valid);
endmodule

// File: rtl/coinc_hist_top.sv
module coinc_hist_top
  import coinc_hist_pkg::*;
#(
  parameter int WORD_W = 11,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtValid,
  input  logic [WORD_W-1:0] evtWord,
  input  logic              pauseReq,
  input  logic              clearReq,
  input  logic              rdEn,
  input  logic [WORD_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  rdData,
  output logic              busy
);
  dpStrobes_t        strb;
  logic [WORD_W-1:0] clrAddr;

  coinc_hist_ctrl #(.WORD_W(WORD_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .pauseReq (pauseReq),
    .clearReq (clearReq),
    .rdEn     (rdEn),
    .strb     (strb),
    .clrAddr  (clrAddr),
    .busy     (busy)
  );

  coinc_hist_dp #(.WORD_W(WORD_W), .CNT_W(CNT_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .clrAddr  (clrAddr),
    .evtValid (evtValid),
    .evtWord  (evtWord),
    .rdAddr   (rdAddr),
    .rdData   (rdData)
  );
endmodule

// File: tb/coinc_hist_top_tb_top.sv
module coinc_hist_top_tb_top;
  localparam int WORD_W = 11;
  localparam int CNT_W  = 8;
  localparam int DEPTH  = 1 << WORD_W;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              evtValid = 1'b0;
  logic [WORD_W-1:0] evtWord = '0;
  logic              pauseReq = 1'b1;
  logic              clearReq = 1'b0;
  logic              rdEn = 1'b0;
  logic [WORD_W-1:0] rdAddr = '0;
  logic [CNT_W-1:0]  rdData;
  logic              busy;

  always #2.5 clk = ~clk;

  coinc_hist_top #(.WORD_W(WORD_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtWord(evtWord),
    .pauseReq(pauseReq), .clearReq(clearReq), .rdEn(rdEn), .rdAddr(rdAddr),
    .rdData(rdData), .busy(busy)
  );

  // behavioural reference
  logic [CNT_W-1:0] mdl [DEPTH];
  logic [CNT_W-1:0] mTotal = '0;
  int    mBusy = 0;
  int    nVec = 0;
  int    nBad = 0;
  string curReq = "R1";
  bit    done = 1'b0;

  function automatic logic [CNT_W-1:0] satInc(logic [CNT_W-1:0] v);
    return (v == CMAX) ? v : v + 1'b1;
  endfunction

  task automatic compare(logic [CNT_W-1:0] act, logic [CNT_W-1:0] exp, string what);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h", curReq, what, act, exp);
    end
  endtask

  // one clock: update model for this edge, then compare outputs after it
  task automatic step();
    bit rdGo = 1'b0;
    logic [CNT_W-1:0] rdExp = '0;
    if (mBusy > 0) begin
      mBusy--;
    end else if (pauseReq && clearReq) begin
      mBusy = DEPTH;
      mTotal = '0;
      for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
    end else begin
      if (!pauseReq && evtValid && evtWord != '0) begin
        mdl[evtWord] = satInc(mdl[evtWord]);
        mTotal = satInc(mTotal);
      end
      if (pauseReq && rdEn) begin
        rdGo = 1'b1;
        rdExp = (rdAddr == '0) ? mTotal : mdl[rdAddr];
      end
    end
    @(posedge clk);
    #1;
    compare(CNT_W'(busy), CNT_W'(mBusy > 0), "busy");
    if (rdGo) compare(rdData, rdExp, $sformatf("rdData[%0d]", rdAddr));
  endtask

  task automatic idle();
    evtValid = 1'b0; clearReq = 1'b0; rdEn = 1'b0;
  endtask

  task automatic event1(int w);
    idle(); evtValid = 1'b1; evtWord = WORD_W'(w); step(); idle();
  endtask

  task automatic readAt(int a);
    idle(); rdEn = 1'b1; rdAddr = WORD_W'(a); step(); idle();
  endtask

  task automatic doClear();
    idle(); clearReq = 1'b1; step(); idle();
    while (mBusy > 0) step();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1; rstN = 1'b1;
    // R1: reset state
    curReq = "R1";
    pauseReq = 1'b1;
    readAt(0);
    step();

    // R9: first clear
    curReq = "R9";
    doClear();
    readAt(0); readAt(5); readAt(DEPTH-1);

    // R2/R4/R5: count patterns
    pauseReq = 1'b0;
    curReq = "R2";
    event1(3); event1(1024); event1(DEPTH-1); event1(7);
    curReq = "R4";
    event1(0); event1(0);
    curReq = "R5";
    for (int i = 0; i < 5; i++) begin evtValid = 1'b1; evtWord = 9; step(); end
    for (int i = 0; i < 6; i++) begin evtValid = 1'b1; evtWord = WORD_W'((i % 2) ? 12 : 13); step(); end
    // burst to 9 then pause straight away and read in the first paused cycle
    evtValid = 1'b1; evtWord = 9; step();
    idle(); pauseReq = 1'b1;
    curReq = "R8";
    readAt(9); readAt(12); readAt(13); readAt(3); readAt(1024); readAt(DEPTH-1); readAt(7);
    curReq = "R3";
    readAt(0);
    curReq = "R4";
    readAt(0);

    // R7: events while paused
    curReq = "R7";
    for (int i = 0; i < 4; i++) begin evtValid = 1'b1; evtWord = 3; step(); end
    readAt(3); readAt(0);

    // R11: resume
    curReq = "R11";
    pauseReq = 1'b0;
    event1(3); event1(3);
    pauseReq = 1'b1; step();
    readAt(3); readAt(0);

    // R6: saturation
    curReq = "R6";
    pauseReq = 1'b0;
    for (int i = 0; i < 300; i++) begin evtValid = 1'b1; evtWord = 5; step(); end
    idle(); pauseReq = 1'b1;
    readAt(5); readAt(0);

    // R9/R10: clear with intrusions mid-sweep
    curReq = "R10";
    idle(); clearReq = 1'b1; step(); idle();
    for (int i = 0; i < 20; i++) begin
      evtValid = 1'b1; evtWord = 5; rdEn = 1'b1; rdAddr = 5; clearReq = (i == 10); step();
    end
    pauseReq = 1'b0;
    for (int i = 0; i < 20; i++) begin evtValid = 1'b1; evtWord = 6; step(); end
    idle(); pauseReq = 1'b1;
    while (mBusy > 0) step();
    curReq = "R9";
    readAt(5); readAt(3); readAt(9); readAt(6); readAt(0); readAt(DEPTH-1);
    curReq = "R11";
    pauseReq = 1'b0;
    event1(6); event1(6);
    pauseReq = 1'b1; step();
    readAt(6); readAt(0);

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin @(posedge clk); cyc++; end
    if (!done) begin
      nVec++; nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule